// File: doc/BRIEF.md
# Codec Control Register Port

This block sits on the codec side of a fixed-rate serial audio link, behind the deserializer. Once per frame the deserializer presents three fields together with a one-cycle `frameStrobe`: the 16-bit tag, the 20-bit command address slot and the 20-bit command data slot. The block also receives the codec's own two-bit identity. It decodes the command, and it updates or reads a file of sixty-four 16-bit control registers.

A frame is accepted only when all of these hold:
- the frame-valid tag bit is set;
- the command slot's tag bit is set;
- the tag's low two bits match the codec identity.

An accepted read produces a status address and status data pair. A serializer then sends this pair in the next input frame. The response is registered on the strobe cycle and held until the following strobe. Register contents have no side effects inside this block.

Top module: `cmdport_regs`

## Requirements
- R1: After reset every register reads as zero and `rspTag`, `rspAddr` and `rspData` are all zero.
- R2: A command is acted on only if tag bit 15 (frame valid) and tag bit 14 (command address slot valid) are both 1. Otherwise no register changes and the next response is all zero.
- R3: A command whose tag bits 1:0 differ from `codecId` is ignored: no register changes and the next response is all zero.
- R4: An accepted command with `cmdAddrIn[19]` = 0 is a write to the index in `cmdAddrIn[18:12]`. The value written is `cmdDataIn[19:4]`.
- R5: A write takes effect only if tag bit 13 (command data slot valid) is also 1 in the same frame.
- R6: Writes to odd indices are discarded. A read of an odd index returns zero data, with the index echoed in `rspAddr`.
- R7: An accepted read (`cmdAddrIn[19]` = 1) updates the response one clock after the strobe. The response is `rspTag` = 16'hE000 (bits 15, 14 and 13 set), `rspAddr[18:12]` = the index, and `rspData[19:4]` = the register value. All other response bits are zero. The outputs do not change between strobes.
- R8: A strobe that carries no accepted read clears all three response outputs to zero one clock later.
- R9: Each of the 64 even indices holds its own value. A write in one frame is returned by a read of the same index in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStrobe | input | 1 | One-cycle pulse; slot inputs are valid this cycle |
| tagIn | input | 16 | Output-frame tag: validity bits and codec identity |
| cmdAddrIn | input | 20 | Command address slot: read/write flag and index |
| cmdDataIn | input | 20 | Command data slot: write data in bits 19:4 |
| codecId | input | 2 | This codec's identity |
| rspTag | output | 16 | Tag validity bits for the next input frame |
| rspAddr | output | 20 | Status address slot: echoed index |
| rspData | output | 20 | Status data slot: register value |

## Verification
A corrupted register can only be seen when that index is read, and the error appears in `rspData` one clock after the read's strobe. The bench therefore writes distinct values to all 64 even indices and then reads every index back. A wrong acceptance decision shows up in the response of the same frame only if that frame is a read. For a write, the error appears later, when the affected index is read. The bench compares all three outputs with a behavioural model on every clock, so a spurious change between strobes is caught within one cycle.

// File: rtl/cmdport_pkg.sv
package cmdport_pkg;
  parameter int TAG_W    = 16;
  parameter int SLOT_W   = 20;
  parameter int DATA_W   = 16;
  parameter int IDX_W    = 7;
  parameter int ID_W     = 2;
  parameter int FRAME_BIT = 15;
  parameter int CMD_BIT   = 14;
  parameter int WDAT_BIT  = 13;

  localparam int NUM_REGS = 2 ** (IDX_W - 1);
  localparam int SEL_W    = IDX_W - 1;
  localparam int ADDR_PAD = SLOT_W - 1 - IDX_W;
  localparam int DATA_PAD = SLOT_W - DATA_W;
  localparam logic [TAG_W-1:0] RSP_TAG =
    TAG_W'((1 << FRAME_BIT) | (1 << CMD_BIT) | (1 << WDAT_BIT));

  typedef struct packed {
    logic             frame;
    logic             wrEn;
    logic             rdEn;
    logic             idxOdd;
    logic [IDX_W-1:0] idx;
  } ctrl_strobes_t;
endpackage

// File: rtl/cmdport_ctrl.sv
module cmdport_ctrl
  import cmdport_pkg::*;
(
  input  logic              frameStrobe,
  input  logic [TAG_W-1:0]  tagIn,
  input  logic [SLOT_W-1:0] cmdAddrIn,
  input  logic [ID_W-1:0]   codecId,
  output ctrl_strobes_t     strobes
);
  logic frameOk;
  logic idMatch;
  logic accepted;
  logic isRead;
  logic [IDX_W-1:0] idx;
  logic unusedBits;

  assign frameOk  = tagIn[FRAME_BIT] & tagIn[CMD_BIT];
  assign idMatch  = (tagIn[ID_W-1:0] == codecId);
  assign accepted = frameStrobe & frameOk & idMatch;
  assign isRead   = cmdAddrIn[SLOT_W-1];
  assign idx      = cmdAddrIn[SLOT_W-2 -: IDX_W];
  assign unusedBits = ^{tagIn[WDAT_BIT-1:ID_W], cmdAddrIn[ADDR_PAD-1:0]};

  always_comb begin
    strobes.frame  = frameStrobe;
    strobes.idx    = idx;
    strobes.idxOdd = idx[0];
    strobes.rdEn   = accepted & isRead;
    strobes.wrEn   = accepted & ~isRead & tagIn[WDAT_BIT] & ~idx[0];
  end
endmodule

// File: rtl/cmdport_regfile.sv
module cmdport_regfile
  import cmdport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobes_t     strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [TAG_W-1:0]  rspTag,
  output logic [SLOT_W-1:0] rspAddr,
  output logic [SLOT_W-1:0] rspData
);
  logic [DATA_W-1:0] regQ [NUM_REGS];
  logic [DATA_W-1:0] rdVal;
  logic [SEL_W-1:0]  sel;

  assign sel = strobes.idx[IDX_W-1:1];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)
        regQ[g] <= '0;
      else if (strobes.wrEn && (sel == SEL_W'(g)))
        regQ[g] <= wrData;
    end
  end

  assign rdVal = strobes.idxOdd ? '0 : regQ[sel];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspTag  <= '0;
      rspAddr <= '0;
      rspData <= '0;
    end else if (strobes.frame) begin
      if (strobes.rdEn) begin
        rspTag  <= RSP_TAG;
        rspAddr <= {1'b0, strobes.idx, {ADDR_PAD{1'b0}}};
        rspData <= {rdVal, {DATA_PAD{1'b0}}};
      end else begin
        rspTag  <= '0;
        rspAddr <= '0;
        rspData <= '0;
      end
    end
  end

  p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rspAddr[SLOT_W-1] == 1'b0) && (rspAddr[ADDR_PAD-1:0] == '0) &&
    (rspData[DATA_PAD-1:0] == '0));

  p_hold_between_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.frame |=> $stable({rspTag, rspAddr, rspData}));
endmodule

// File: rtl/cmdport_regs.sv
module cmdport_regs
  import cmdport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStrobe,
  input  logic [TAG_W-1:0]  tagIn,
  input  logic [SLOT_W-1:0] cmdAddrIn,
  input  logic [SLOT_W-1:0] cmdDataIn,
  input  logic [ID_W-1:0]   codecId,
  output logic [TAG_W-1:0]  rspTag,
  output logic [SLOT_W-1:0] rspAddr,
  output logic [SLOT_W-1:0] rspData
);
  ctrl_strobes_t strobes;
  logic unusedBits;

  assign unusedBits = ^cmdDataIn[DATA_PAD-1:0];

  cmdport_ctrl u_ctrl (
    .frameStrobe(frameStrobe),
    .tagIn      (tagIn),
    .cmdAddrIn  (cmdAddrIn),
    .codecId    (codecId),
    .strobes    (strobes)
  );

  cmdport_regfile u_regfile (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wrData (cmdDataIn[SLOT_W-1 -: DATA_W]),
    .rspTag (rspTag),
    .rspAddr(rspAddr),
    .rspData(rspData)
  );

  p_needs_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe && !(tagIn[FRAME_BIT] && tagIn[CMD_BIT]) |=> rspTag == '0);

  p_id_mismatch_r3: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe && (tagIn[ID_W-1:0] != codecId) |=> rspTag == '0);

  p_odd_read_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe && tagIn[FRAME_BIT] && tagIn[CMD_BIT] &&
    (tagIn[ID_W-1:0] == codecId) && cmdAddrIn[SLOT_W-1] &&
    cmdAddrIn[SLOT_W-1-IDX_W] |=> rspData == '0);

  p_rsp_flags_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rspTag != '0) |-> (rspTag == RSP_TAG));

  p_no_read_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe && !cmdAddrIn[SLOT_W-1] |=> (rspTag == '0) && (rspData == '0));
endmodule

// File: tb/tb_cmdport_regs.sv
module tb_cmdport_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStrobe = 1'b0;
  logic [15:0] tagIn = '0;
  logic [19:0] cmdAddrIn = '0;
  logic [19:0] cmdDataIn = '0;
  logic [1:0]  codecId = 2'b01;
  logic [15:0] rspTag;
  logic [19:0] rspAddr;
  logic [19:0] rspData;

  int testsRun = 0;
  int testsFailed = 0;
  string curReq = "R1";

  int refMem [64];
  logic [15:0] expTag = '0;
  logic [19:0] expAddr = '0;
  logic [19:0] expData = '0;

  always #10 clk = ~clk;

  cmdport_regs dut (
    .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe), .tagIn(tagIn),
    .cmdAddrIn(cmdAddrIn), .cmdDataIn(cmdDataIn), .codecId(codecId),
    .rspTag(rspTag), .rspAddr(rspAddr), .rspData(rspData)
  );

  // Behavioural reference model
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 64; i++) refMem[i] = 0;
      expTag = '0; expAddr = '0; expData = '0;
    end else if (frameStrobe) begin
      automatic bit acc = tagIn[15] && tagIn[14] && (tagIn[1:0] == codecId);
      automatic int ix  = int'(cmdAddrIn[18:12]);
      if (acc && !cmdAddrIn[19] && tagIn[13] && (ix % 2 == 0))
        refMem[ix / 2] = int'(cmdDataIn[19:4]);
      if (acc && cmdAddrIn[19]) begin
        expTag  = 16'hE000;
        expAddr = 20'(ix) << 12;
        expData = (ix % 2 == 0) ? (20'(refMem[ix / 2]) << 4) : 20'h0;
      end else begin
        expTag = '0; expAddr = '0; expData = '0;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      chk({curReq, " tag"},  32'(rspTag),  32'(expTag));
      chk({curReq, " addr"}, 32'(rspAddr), 32'(expAddr));
      chk({curReq, " data"}, 32'(rspData), 32'(expData));
    end
  end

  function automatic logic [15:0] mkTag(bit f, bit s1, bit s2, logic [1:0] id);
    return {f, s1, s2, 11'b0, id};
  endfunction

  task automatic sendFrame(logic [15:0] t, bit rd, logic [6:0] ix, logic [15:0] d);
    @(negedge clk);
    tagIn = t; cmdAddrIn = {rd, ix, 12'b0}; cmdDataIn = rd ? 20'h0 : {d, 4'b0};
    frameStrobe = 1'b1;
    @(negedge clk);
    frameStrobe = 1'b0; tagIn = '0; cmdAddrIn = '0; cmdDataIn = '0;
    @(negedge clk);
  endtask

  task automatic wr(logic [6:0] ix, logic [15:0] d);
    sendFrame(mkTag(1, 1, 1, codecId), 1'b0, ix, d);
  endtask

  task automatic rdChk(string req, logic [6:0] ix, logic [15:0] expVal);
    sendFrame(mkTag(1, 1, 0, codecId), 1'b1, ix, 16'h0);
    chk(req, 32'(rspData[19:4]), 32'(expVal));
    chk(req, 32'(rspAddr[18:12]), 32'(ix));
  endtask

  initial begin
    #(20 * 150000);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset tag", 32'(rspTag), 32'h0);
    rstN = 1'b1;
    curReq = "R1";
    rdChk("R1", 7'd0, 16'h0);
    rdChk("R1", 7'd126, 16'h0);

    curReq = "R4";
    wr(7'd2, 16'h1234);
    rdChk("R4", 7'd2, 16'h1234);
    wr(7'd126, 16'hFFFF);
    rdChk("R4", 7'd126, 16'hFFFF);
    chk("R7 tag", 32'(rspTag), 32'hE000);

    curReq = "R9";
    for (int i = 0; i < 64; i++) wr(7'(2 * i), 16'(i * 257) ^ 16'h5A5A);
    for (int i = 0; i < 64; i++) rdChk("R9", 7'(2 * i), 16'(i * 257) ^ 16'h5A5A);

    curReq = "R5";
    sendFrame(mkTag(1, 1, 0, codecId), 1'b0, 7'd2, 16'hDEAD);
    rdChk("R5", 7'd2, 16'h5B5B);

    curReq = "R6";
    wr(7'd3, 16'hBEEF);
    rdChk("R6", 7'd3, 16'h0);
    rdChk("R6", 7'd2, 16'h5B5B);

    curReq = "R2";
    sendFrame(mkTag(0, 1, 1, codecId), 1'b0, 7'd4, 16'h1111);
    sendFrame(mkTag(1, 0, 1, codecId), 1'b0, 7'd4, 16'h2222);
    sendFrame(mkTag(0, 1, 0, codecId), 1'b1, 7'd4, 16'h0);
    chk("R2 no response", 32'(rspTag), 32'h0);
    rdChk("R2", 7'd4, 16'h5858);

    curReq = "R3";
    sendFrame(mkTag(1, 1, 1, 2'b10), 1'b0, 7'd6, 16'h3333);
    sendFrame(mkTag(1, 1, 0, 2'b00), 1'b1, 7'd6, 16'h0);
    chk("R3 no response", 32'(rspTag), 32'h0);
    rdChk("R3", 7'd6, 16'h5959);

    curReq = "R8";
    wr(7'd8, 16'hA5A5);
    chk("R8 cleared", 32'(rspData), 32'h0);
    curReq = "R7";
    rdChk("R7", 7'd8, 16'hA5A5);
    repeat (5) @(negedge clk);
    chk("R7 held", 32'(rspData), 32'hA5A50);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule